// File: doc/BRIEF.md
# Card Access Strobe Timing Sequencer

This block carries out one card bus access once a window hit has been decoded. It takes the selected window's 32-bit option word and pulls three cycle counts out of it: setup, strobe length and hold. It then steps through three phases. First comes an address-setup phase, then an active strobe phase, then a hold phase. The card strobe is asserted only in the middle phase. Read data is captured on the last strobe cycle, and a one-cycle done pulse ends the access.

The whole access is watched by a bus-monitor limit. An access whose total length reaches the limit is cut off at that cycle and ends with an error. Each slot also has an 8-bit general control byte. The block turns that byte into a registered, active-high card reset and a registered, active-low output enable for the card-side buffers. A request for a slot that is held in reset completes at once with an error and does not strobe. Address decoding and data width conversion are handled by neighbouring logic.

Top module: `card_strobe_seq`

## Requirements
- R1: After a request is accepted in idle, the setup phase lasts opt_i[15:12] cycles with strobe_o low. A setup value of zero skips the phase, so strobe_o is high in the first access cycle.
- R2: strobe_o is high for exactly opt_i[11:7] consecutive cycles right after setup. A strobe value of zero gives one strobe cycle.
- R3: The hold phase follows the strobe phase and lasts opt_i[19:16] cycles with strobe_o low. A hold value of zero skips the phase.
- R4: done_o is high for one cycle, in the cycle after the last access cycle. busy_o is high in every access cycle and low otherwise.
- R5: Option bits outside 19:7 have no effect on the timing.
- R6: rd_data_o takes the value of card_rd_i present in the last strobe cycle and holds it afterwards.
- R7: Let the total be setup + effective strobe + hold, where the effective strobe is the strobe value with zero counted as one. If the total is below BMT_LIMIT (default 60), the access ends with err_o low. If the total is BMT_LIMIT or more, the access ends after exactly BMT_LIMIT cycles, with done_o and err_o high together.
- R8: req_i is ignored while an access is in progress. A new access is accepted only in idle, which includes the cycle in which done_o is high.
- R9: A request for a slot whose card_reset_o is high is answered in the next cycle with done_o and err_o high. That cycle has busy_o low and no strobe.
- R10: card_reset_o[s] equals gcr_i[8*s+6] one cycle later, and is 1 out of reset.
- R11: card_oe_no[s] equals gcr_i[8*s+7] one cycle later, so a one turns the buffers off. It is 1 out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Window hit, start an access |
| slot_i | input | 1 | Slot of the hit window |
| opt_i | input | 32 | Option word of the hit window (hold 19:16, setup 15:12, strobe 11:7) |
| gcr_i | input | 16 | Per-slot control bytes, slot s in bits 8s+7:8s |
| card_rd_i | input | 16 | Read data from the card |
| rd_data_o | output | 16 | Captured read data |
| strobe_o | output | 1 | Card access strobe |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access finished, one-cycle pulse |
| err_o | output | 1 | Access ended by timeout or by a slot in reset |
| card_reset_o | output | 2 | Per-slot card reset, active high |
| card_oe_no | output | 2 | Per-slot buffer enable, active low |

## Verification
The bench runs accesses with several setup, strobe and hold mixes, including zero setup, zero hold and zero strobe. Each mix shows whether a phase is wrongly kept or wrongly dropped, and whether the zero-strobe case is stretched to one cycle. The card data changes every cycle, so the captured value identifies the exact cycle in which it was taken. Totals of 59, 60 and 61 cycles separate a clean end, an error on exactly reaching the limit, and an abort partway through the hold phase. A request held high during a whole access checks that the busy request is ignored, and a slot held in reset checks the immediate error path.

// File: rtl/cst_pkg.sv
package cst_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_e;

  localparam int STRB_LSB  = 7;
  localparam int STRB_W    = 5;
  localparam int SETUP_LSB = 12;
  localparam int SETUP_W   = 4;
  localparam int HOLD_LSB  = 16;
  localparam int HOLD_W    = 4;

  typedef struct packed {
    logic [HOLD_W-1:0]  hold;
    logic [SETUP_W-1:0] setup;
    logic [STRB_W-1:0]  strobe;  // already normalized, never zero
  } timing_t;
endpackage

// File: rtl/cst_field_unpack.sv
module cst_field_unpack
  import cst_pkg::*;
(
  input  logic [31:0] opt_i,
  output timing_t     tim_o
);
  logic [STRB_W-1:0] strb_raw;
  logic              unused_opt;

  assign strb_raw     = opt_i[STRB_LSB +: STRB_W];
  assign tim_o.setup  = opt_i[SETUP_LSB +: SETUP_W];
  assign tim_o.hold   = opt_i[HOLD_LSB +: HOLD_W];
  assign tim_o.strobe = (strb_raw == '0) ? STRB_W'(1) : strb_raw;
  assign unused_opt   = ^opt_i;
endmodule

// File: rtl/cst_slot_ctrl.sv
module cst_slot_ctrl #(
  parameter int NUM_SLOTS = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_SLOTS*8-1:0] gcr_i,
  output logic [NUM_SLOTS-1:0]   card_reset_o,
  output logic [NUM_SLOTS-1:0]   card_oe_no
);
  localparam int RST_BIT = 6;
  localparam int OE_BIT  = 7;

  logic unused_gcr;
  assign unused_gcr = ^gcr_i;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    // safe state out of reset: card held in reset, buffers off
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        card_reset_o[s] <= 1'b1;
        card_oe_no[s]   <= 1'b1;
      end else begin
        card_reset_o[s] <= gcr_i[s*8+RST_BIT];
        card_oe_no[s]   <= gcr_i[s*8+OE_BIT];
      end
    end
  end
endmodule

// File: rtl/cst_phase_fsm.sv
module cst_phase_fsm
  import cst_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int SLOT_W    = 1,
  parameter int DATA_W    = 16,
  parameter int BMT_LIMIT = 60,
  localparam int CNT_W    = $clog2(BMT_LIMIT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  timing_t              tim_i,
  input  logic [NUM_SLOTS-1:0] slot_rst_i,
  input  logic [DATA_W-1:0]    card_rd_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic                 strobe_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o
);
  phase_e            st_q;
  timing_t           tim_q;
  logic [STRB_W-1:0] ph_cnt_q;
  logic [STRB_W-1:0] cur_len;
  logic [CNT_W-1:0]  tot_cnt_q;
  logic              ph_end;
  logic              timeout;

  always_comb begin
    unique case (st_q)
      PH_SETUP:  cur_len = STRB_W'(tim_q.setup);
      PH_STROBE: cur_len = tim_q.strobe;
      PH_HOLD:   cur_len = STRB_W'(tim_q.hold);
      default:   cur_len = STRB_W'(1);
    endcase
  end

  assign ph_end  = (ph_cnt_q == cur_len);
  assign timeout = (tot_cnt_q == CNT_W'(BMT_LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= PH_IDLE;
      tim_q     <= '0;
      ph_cnt_q  <= '0;
      tot_cnt_q <= '0;
      rd_data_o <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (st_q == PH_IDLE) begin
        if (req_i) begin
          tim_q <= tim_i;
          if (slot_rst_i[slot_i]) begin
            done_o <= 1'b1;
            err_o  <= 1'b1;
          end else begin
            st_q      <= (tim_i.setup != '0) ? PH_SETUP : PH_STROBE;
            ph_cnt_q  <= STRB_W'(1);
            tot_cnt_q <= CNT_W'(1);
          end
        end
      end else begin
        if (st_q == PH_STROBE && ph_end) rd_data_o <= card_rd_i;
        if (timeout) begin
          // bus monitor wins over a normal phase end
          st_q   <= PH_IDLE;
          done_o <= 1'b1;
          err_o  <= 1'b1;
        end else if (ph_end) begin
          ph_cnt_q  <= STRB_W'(1);
          tot_cnt_q <= tot_cnt_q + 1'b1;
          unique case (st_q)
            PH_SETUP: st_q <= PH_STROBE;
            PH_STROBE: begin
              if (tim_q.hold != '0) st_q <= PH_HOLD;
              else begin
                st_q   <= PH_IDLE;
                done_o <= 1'b1;
              end
            end
            default: begin
              st_q   <= PH_IDLE;
              done_o <= 1'b1;
            end
          endcase
        end else begin
          ph_cnt_q  <= ph_cnt_q + 1'b1;
          tot_cnt_q <= tot_cnt_q + 1'b1;
        end
      end
    end
  end

  assign strobe_o = (st_q == PH_STROBE);
  assign busy_o   = (st_q != PH_IDLE);
endmodule

// File: rtl/card_strobe_seq.sv
module card_strobe_seq
  import cst_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int DATA_W    = 16,
  parameter int BMT_LIMIT = 60,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [SLOT_W-1:0]      slot_i,
  input  logic [31:0]            opt_i,
  input  logic [NUM_SLOTS*8-1:0] gcr_i,
  input  logic [DATA_W-1:0]      card_rd_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   strobe_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   err_o,
  output logic [NUM_SLOTS-1:0]   card_reset_o,
  output logic [NUM_SLOTS-1:0]   card_oe_no
);
  timing_t tim;

  cst_field_unpack i_unpack (
    .opt_i (opt_i),
    .tim_o (tim)
  );

  cst_slot_ctrl #(.NUM_SLOTS(NUM_SLOTS)) i_slot_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gcr_i        (gcr_i),
    .card_reset_o (card_reset_o),
    .card_oe_no   (card_oe_no)
  );

  cst_phase_fsm #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W),
    .DATA_W    (DATA_W),
    .BMT_LIMIT (BMT_LIMIT)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .slot_i     (slot_i),
    .tim_i      (tim),
    .slot_rst_i (card_reset_o),
    .card_rd_i  (card_rd_i),
    .rd_data_o  (rd_data_o),
    .strobe_o   (strobe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/cst_checker.sv
module cst_checker #(
  parameter int NUM_SLOTS = 2,
  parameter int SLOT_W    = 1,
  parameter int BMT_LIMIT = 60,
  localparam int RUN_W    = $clog2(BMT_LIMIT + 2) + 1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_i,
  input logic [SLOT_W-1:0]      slot_i,
  input logic [NUM_SLOTS*8-1:0] gcr_i,
  input logic                   strobe_o,
  input logic                   busy_o,
  input logic                   done_o,
  input logic                   err_o,
  input logic [NUM_SLOTS-1:0]   card_reset_o,
  input logic [NUM_SLOTS-1:0]   card_oe_no
);
  logic [RUN_W-1:0] run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  p_bus_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (run_cnt < RUN_W'(BMT_LIMIT)));

  p_err_ends_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && !busy_o));

  p_strobe_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_o) |-> (busy_o || done_o));

  p_idle_after_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !strobe_o);

  p_reset_slot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && card_reset_o[slot_i]) |=> (done_o && err_o && !strobe_o));

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
    p_card_reset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      card_reset_o[s] == $past(gcr_i[s*8+6]));
    p_buf_enable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      card_oe_no[s] == $past(gcr_i[s*8+7]));
  end
endmodule

bind card_strobe_seq cst_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .SLOT_W    (SLOT_W),
  .BMT_LIMIT (BMT_LIMIT)
) i_cst_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .slot_i       (slot_i),
  .gcr_i        (gcr_i),
  .strobe_o     (strobe_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o),
  .card_reset_o (card_reset_o),
  .card_oe_no   (card_oe_no)
);

// File: tb/test_card_strobe_seq.sv
module test_card_strobe_seq;
  localparam int LIM = 60;
  localparam logic [31:0] JUNK = 32'hABC0_0055;  // bits outside 19:7 (R5)

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [0:0]  slot = 1'b0;
  logic [31:0] opt = '0;
  logic [15:0] gcr = 16'hC0C0;
  logic [15:0] card_rd = '0;
  logic [15:0] rd_data;
  logic        strobe, busy, done, err;
  logic [1:0]  card_reset, card_oe_n;

  int tests = 0;
  int fails = 0;
  bit fin = 1'b0;

  always #2 clk = ~clk;

  card_strobe_seq i_card_strobe_seq (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_i        (req),
    .slot_i       (slot),
    .opt_i        (opt),
    .gcr_i        (gcr),
    .card_rd_i    (card_rd),
    .rd_data_o    (rd_data),
    .strobe_o     (strobe),
    .busy_o       (busy),
    .done_o       (done),
    .err_o        (err),
    .card_reset_o (card_reset),
    .card_oe_no   (card_oe_n)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset_state();
    chk("R10 R11 reset outputs", {card_reset, card_oe_n}, 4'b1111);
    chk("R4 reset idle", {busy, done, err, strobe}, 4'b0000);
  endtask

  task automatic t_slot_ctrl();
    @(negedge clk); gcr = 16'h4080;  // slot1 reset on, slot0 buffers off
    chk("R10 R11 no change before edge", {card_reset, card_oe_n}, 4'b1111);
    @(negedge clk);
    chk("R10 card reset follows bit 6", card_reset, 2'b10);
    chk("R11 buffer enable follows bit 7", card_oe_n, 2'b01);
    @(negedge clk); gcr = 16'h0000;
    @(negedge clk);
    chk("R10 R11 released", {card_reset, card_oe_n}, 4'b0000);
  endtask

  // one access on slot 0, checked cycle by cycle
  task automatic t_access(string tag, int s, int l, int h);
    int le = (l == 0) ? 1 : l;
    int t = s + le + h;
    int n = (t >= LIM) ? LIM : t;
    logic e = (t >= LIM);
    @(negedge clk);
    opt = JUNK | (32'(h) << 16) | (32'(s) << 12) | (32'(l) << 7);
    slot = 1'b0; req = 1'b1;
    @(negedge clk); req = 1'b0;
    for (int i = 1; i <= n; i++) begin
      if (i > 1) @(negedge clk);
      card_rd = 16'(i);
      chk({tag, " R1 R2 R3 phase"}, {busy, strobe}, {1'b1, (i > s) && (i <= s + le)});
    end
    @(negedge clk);
    chk({tag, " R4 R7 end"}, {done, err, busy, strobe}, {1'b1, e, 2'b00});
    if (s + le <= n) chk({tag, " R6 capture"}, rd_data, 32'(s + le));
    @(negedge clk);
    chk({tag, " R4 single pulse"}, {done, busy}, 2'b00);
  endtask

  task automatic t_busy_ignore();
    int n = 2 + 3 + 2;
    int strb = 0;
    @(negedge clk);
    opt = (32'd2 << 16) | (32'd2 << 12) | (32'd3 << 7);
    slot = 1'b0; req = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (strobe) strb++;
      if (i == n) req = 1'b0;
    end
    @(negedge clk);
    chk("R8 done after one access", {done, busy}, 2'b10);
    chk("R8 one strobe run", 32'(strb), 32'd3);
    @(negedge clk);
    chk("R8 no second access", {busy, done}, 2'b00);
  endtask

  task automatic t_reset_slot();
    @(negedge clk); gcr = 16'h4000;
    @(negedge clk);
    opt = (32'd1 << 16) | (32'd1 << 12) | (32'd2 << 7);
    slot = 1'b1; req = 1'b1;
    @(negedge clk); req = 1'b0;
    chk("R9 immediate error", {done, err, busy, strobe}, 4'b1100);
    @(negedge clk);
    chk("R9 stays idle", {done, busy, strobe}, 3'b000);
    gcr = 16'h0000;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_slot_ctrl();
    t_access("basic", 2, 3, 2);
    t_access("no setup no hold", 0, 4, 0);
    t_access("zero strobe", 5, 0, 1);
    t_access("hold only", 0, 1, 3);
    t_access("below limit", 13, 31, 15);
    t_access("at limit", 14, 31, 15);
    t_access("over limit", 15, 31, 15);
    t_busy_ignore();
    t_reset_slot();
    t_access("after reset slot", 1, 2, 1);
    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule